// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the ordered list of column addresses that a synchronous DRAM burst visits. A controller pulses the start strobe with the first column. It also gives the burst settings: the length code, the ordering bit, the write flag and the single-write bit. From the next enabled clock the block presents one column per beat. A valid flag marks each beat, and a last-beat flag marks the final beat of a fixed burst.

Fixed bursts stay inside the aligned block of their own length. The order is either counting upward with wrap-around, or the starting column XOR the beat number. A page burst walks the whole 1024-column row and keeps going until a stop strobe or a new command arrives. A new command always restarts the sequence, even one cycle after the previous one. When the clock enable input is low, the block holds every output as it is.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is applied, col_valid and col_last are 0 and col_out is 0.
- R2: A start sampled with cke high makes the next cycle beat 0, with col_valid high and col_out equal to cmd_col.
- R3: The cfg_len code selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give a page burst. A fixed burst has exactly that many valid beats. col_last is high only on the final beat, and col_valid falls on the following enabled cycle.
- R4: With cfg_ilv at 0, a fixed burst adds the beat number to the start column on the low log2(length) bits only, wrapping inside the aligned block. The bits above are held.
- R5: With cfg_ilv at 1, a fixed burst outputs the start column XOR the beat number on the low log2(length) bits. The bits above are held.
- R6: A page burst outputs the start column plus the beat number modulo 1024, whatever cfg_ilv is. It has no natural end, and col_last stays 0 throughout.
- R7: burst_stop sampled with cke high and no start ends the burst: col_valid is 0 in the next cycle.
- R8: A start during a burst abandons that burst and begins beat 0 of the new one in the next cycle. When start and stop arrive together, the start wins.
- R9: If cfg_single_write and cmd_write are both 1 at start, the burst is one beat long whatever the length code is. A read burst uses the programmed length.
- R10: When cke is sampled low, no state changes: col_out, col_valid and col_last keep their values in the next cycle.
- R11: The length, ordering and write settings are captured at start. Changing them during a burst does not alter that burst's columns or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; low freezes the block |
| cmd_start | input | 1 | Column command strobe |
| cmd_col | input | 10 | Starting column of the command |
| cmd_write | input | 1 | 1 for a write command, 0 for a read |
| cfg_len | input | 3 | Burst length code (see R3) |
| cfg_ilv | input | 1 | 0 sequential, 1 interleaved ordering |
| cfg_single_write | input | 1 | Forces write bursts to one beat |
| burst_stop | input | 1 | Terminates the running burst |
| col_out | output | 10 | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Final beat of a fixed burst |

## Verification
The ordering logic is tried with start columns whose low bits are nonzero and whose upper bits are all ones or mixed. A sequential wrap then gives different columns from an interleaved burst, and different again from a plain increment that carries into the upper bits. A page burst started two columns below the row end shows modulo-1024 wrap and that col_last never rises. Writes are sent with the single-write bit on and off, and reads with it on, so that the override is seen to apply only to writes. Clock-enable gaps are placed on the final beat and on beat 0, where a freeze that lost one beat or repeated one would show. Long random runs mix commands issued one cycle apart, stops, and settings that change mid-burst; these are compared against a bench model.

// File: rtl/sdram_burst_colgen_pkg.sv
package sdram_burst_colgen_pkg;
  localparam int unsigned LEN_CODE_W   = 3;
  localparam int unsigned FIXED_CODE_MAX = 3;

  typedef enum logic [LEN_CODE_W-1:0] {
    LEN_ONE   = 3'd0,
    LEN_TWO   = 3'd1,
    LEN_FOUR  = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE  = 3'd7
  } len_code_e;

  function automatic logic code_is_page(input logic [LEN_CODE_W-1:0] code);
    return code > LEN_CODE_W'(FIXED_CODE_MAX);
  endfunction
endpackage

// File: rtl/cbg_rst_sync.sv
module cbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cbg_len_decode.sv
module cbg_len_decode
  import sdram_burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  is_write,
  input  logic                  single_write,
  output logic [COL_W-1:0]      wrap_mask,
  output logic                  page_mode
);
  logic force_one;
  logic [COL_W-1:0] raw_mask;

  assign force_one = is_write & single_write;

  // a code n in the fixed range opens the n lowest column bits
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign raw_mask[i] = (LEN_CODE_W'(i) < len_code) && (i < FIXED_CODE_MAX);
  end

  always_comb begin
    if (force_one) begin
      wrap_mask = '0;
      page_mode = 1'b0;
    end else if (code_is_page(len_code)) begin
      wrap_mask = '0;
      page_mode = 1'b1;
    end else begin
      wrap_mask = raw_mask;
      page_mode = 1'b0;
    end
  end
endmodule

// File: rtl/cbg_beat_ctl.sv
module cbg_beat_ctl #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] new_mask,
  input  logic             new_page,
  input  logic             new_ilv,
  output logic             valid_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] mask_q,
  output logic             page_q,
  output logic             ilv_q,
  output logic             at_end
);
  logic             valid_d;
  logic [COL_W-1:0] beat_d;
  logic [COL_W-1:0] base_d;
  logic [COL_W-1:0] mask_d;
  logic             page_d;
  logic             ilv_d;

  assign at_end = valid_q & ~page_q & (beat_q == mask_q);

  always_comb begin
    valid_d = valid_q;
    beat_d  = beat_q;
    base_d  = base_q;
    mask_d  = mask_q;
    page_d  = page_q;
    ilv_d   = ilv_q;
    if (start) begin
      valid_d = 1'b1;
      beat_d  = '0;
      base_d  = start_col;
      mask_d  = new_mask;
      page_d  = new_page;
      ilv_d   = new_ilv;
    end else if (valid_q) begin
      if (stop || at_end) valid_d = 1'b0;
      else                beat_d  = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      page_q  <= 1'b0;
      ilv_q   <= 1'b0;
    end else if (cke) begin
      valid_q <= valid_d;
      beat_q  <= beat_d;
      base_q  <= base_d;
      mask_q  <= mask_d;
      page_q  <= page_d;
      ilv_q   <= ilv_d;
    end
  end
endmodule

// File: rtl/cbg_col_map.sv
module cbg_col_map #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             page,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;

  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (page)         col[i] = sum[i];
      else if (!mask[i]) col[i] = base[i];
      else if (ilv)     col[i] = base[i] ^ beat[i];
      else              col[i] = sum[i];
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke,
  input  logic                  cmd_start,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic                  cmd_write,
  input  logic [LEN_CODE_W-1:0] cfg_len,
  input  logic                  cfg_ilv,
  input  logic                  cfg_single_write,
  input  logic                  burst_stop,
  output logic [COL_W-1:0]      col_out,
  output logic                  col_valid,
  output logic                  col_last
);
  logic             rst_sync_n;
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             page_q;
  logic             ilv_q;
  logic             valid_q;
  logic             at_end;

  cbg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cbg_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code     (cfg_len),
    .is_write     (cmd_write),
    .single_write (cfg_single_write),
    .wrap_mask    (dec_mask),
    .page_mode    (dec_page)
  );

  cbg_beat_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cke       (cke),
    .start     (cmd_start),
    .stop      (burst_stop),
    .start_col (cmd_col),
    .new_mask  (dec_mask),
    .new_page  (dec_page),
    .new_ilv   (cfg_ilv),
    .valid_q   (valid_q),
    .beat_q    (beat_q),
    .base_q    (base_q),
    .mask_q    (mask_q),
    .page_q    (page_q),
    .ilv_q     (ilv_q),
    .at_end    (at_end)
  );

  cbg_col_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_q),
    .mask (mask_q),
    .page (page_q),
    .ilv  (ilv_q),
    .col  (col_out)
  );

  assign col_valid = valid_q;
  assign col_last  = at_end;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cke,
  input logic             cmd_start,
  input logic [COL_W-1:0] cmd_col,
  input logic             cmd_write,
  input logic             cfg_single_write,
  input logic             burst_stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last,
  input logic [COL_W-1:0] mask_q,
  input logic             page_q
);
  assert_start_beat0_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cke && cmd_start |=> col_valid && col_out == $past(cmd_col));

  assert_last_ends_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cke && col_last && !cmd_start |=> !col_valid);

  assert_last_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    col_last |-> col_valid);

  assert_upper_held_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cke && col_valid && !page_q && !cmd_start && !burst_stop && !col_last
    |=> ((col_out ^ $past(col_out)) & ~$past(mask_q)) == '0);

  assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    page_q |-> !col_last);

  assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cke && burst_stop && !cmd_start |=> !col_valid);

  assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cke && cmd_start && cmd_write && cfg_single_write |=> col_last);

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cke |=> $stable(col_out) && $stable(col_valid) && $stable(col_last));
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk              (clk),
  .rst_sync_n       (rst_sync_n),
  .cke              (cke),
  .cmd_start        (cmd_start),
  .cmd_col          (cmd_col),
  .cmd_write        (cmd_write),
  .cfg_single_write (cfg_single_write),
  .burst_stop       (burst_stop),
  .col_out          (col_out),
  .col_valid        (col_valid),
  .col_last         (col_last),
  .mask_q           (mask_q),
  .page_q           (page_q)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cke;
  logic             cmd_start;
  logic [COL_W-1:0] cmd_col;
  logic             cmd_write;
  logic [2:0]       cfg_len;
  logic             cfg_ilv;
  logic             cfg_single_write;
  logic             burst_stop;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  int n_vec  = 0;
  int n_fail = 0;

  logic             m_valid = 1'b0;
  logic [COL_W-1:0] m_base = '0, m_beat = '0, m_mask = '0;
  logic             m_page = 1'b0, m_ilv = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd_start(cmd_start), .cmd_col(cmd_col),
    .cmd_write(cmd_write), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .cfg_single_write(cfg_single_write), .burst_stop(burst_stop),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last));

  function automatic logic [COL_W-1:0] len_mask(input logic [2:0] code);
    case (code)
      3'd0: return 10'h000;
      3'd1: return 10'h001;
      3'd2: return 10'h003;
      3'd3: return 10'h007;
      default: return 10'h000;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] exp_col();
    logic [COL_W-1:0] s;
    s = m_base + m_beat;
    if (m_page) return s;
    if (m_ilv)  return (m_base & ~m_mask) | ((m_base ^ m_beat) & m_mask);
    return (m_base & ~m_mask) | (s & m_mask);
  endfunction

  function automatic logic exp_last();
    return m_valid && !m_page && (m_beat == m_mask);
  endfunction

  task automatic compare(input string tag);
    logic ev, el;
    logic [COL_W-1:0] ec;
    ev = m_valid; el = exp_last(); ec = exp_col();
    n_vec++;
    if (col_valid !== ev || col_last !== el || (ev && col_out !== ec)) begin
      n_fail++;
      $display("FAIL %s: valid/last/col = %0b/%0b/%h expected %0b/%0b/%h",
               tag, col_valid, col_last, col_out, ev, el, ec);
    end
  endtask

  task automatic step(input logic e, input logic st, input logic [COL_W-1:0] c,
                      input logic wr, input logic [2:0] len, input logic il,
                      input logic sp, input logic sw, input string tag);
    cke = e; cmd_start = st; cmd_col = c; cmd_write = wr; cfg_len = len;
    cfg_ilv = il; burst_stop = sp; cfg_single_write = sw;
    if (e) begin
      if (st) begin
        m_valid = 1'b1; m_beat = '0; m_base = c; m_ilv = il;
        if (wr && sw) begin m_mask = '0; m_page = 1'b0; end
        else begin m_mask = len_mask(len); m_page = (len > 3'd3); end
      end else if (m_valid) begin
        if (sp || exp_last()) m_valid = 1'b0;
        else m_beat = m_beat + 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, '0, 0, 3'd0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cke = 1'b1; cmd_start = 1'b0; cmd_col = '0; cmd_write = 1'b0;
    cfg_len = 3'd0; cfg_ilv = 1'b0; cfg_single_write = 1'b0; burst_stop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle during reset
    n_vec++;
    if (col_valid !== 1'b0 || col_last !== 1'b0 || col_out !== '0) begin
      n_fail++;
      $display("FAIL R1: valid/last/col = %0b/%0b/%h expected 0/0/000", col_valid, col_last, col_out);
    end
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R4 sequential length 8, start low bits 5, upper bits mixed
    step(1, 1, 10'h2D5, 0, 3'd3, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) step(1, 0, '0, 0, 3'd3, 0, 0, 0, "R4");
    // R5 interleaved length 4 with upper bits all ones
    step(1, 1, 10'h3FE, 0, 3'd2, 1, 0, 0, "R5");
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 3'd2, 1, 0, 0, "R5");
    // R3 lengths 1 and 2
    step(1, 1, 10'h101, 0, 3'd0, 0, 0, 0, "R3");
    step(1, 0, '0, 0, 3'd0, 0, 0, 0, "R3");
    step(1, 1, 10'h0FF, 0, 3'd1, 1, 0, 0, "R3");
    idle(2, "R3");
    // R6 page burst across the row end, then R7 stop
    step(1, 1, 10'h3FE, 0, 3'd7, 1, 0, 0, "R6");
    for (int i = 0; i < 5; i++) step(1, 0, '0, 0, 3'd7, 1, 0, 0, "R6");
    step(1, 0, '0, 0, 3'd7, 0, 1, 0, "R7");
    idle(1, "R7");
    // R8 back-to-back restart, then start with stop together
    step(1, 1, 10'h040, 0, 3'd3, 0, 0, 0, "R8");
    step(1, 1, 10'h123, 0, 3'd2, 0, 0, 0, "R8");
    step(1, 0, '0, 0, 3'd2, 0, 0, 0, "R8");
    step(1, 1, 10'h200, 0, 3'd1, 0, 1, 0, "R8");
    idle(3, "R8");
    // R9 single-write: write forced to one beat, read keeps length
    step(1, 1, 10'h016, 1, 3'd3, 0, 0, 1, "R9");
    step(1, 0, '0, 0, 3'd3, 0, 0, 1, "R9");
    step(1, 1, 10'h016, 0, 3'd2, 0, 0, 1, "R9");
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 3'd2, 0, 0, 1, "R9");
    step(1, 1, 10'h016, 1, 3'd2, 0, 0, 0, "R9");
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, 3'd2, 0, 0, 0, "R9");
    // R10 freeze on beat 0 and on last beat, inputs toggling meanwhile
    step(1, 1, 10'h0A1, 0, 3'd1, 0, 0, 0, "R10");
    step(0, 1, 10'h3C3, 0, 3'd3, 1, 1, 0, "R10");
    step(0, 0, '0, 0, 3'd0, 0, 1, 0, "R10");
    step(1, 0, '0, 0, 3'd1, 0, 0, 0, "R10");
    step(0, 0, '0, 0, 3'd1, 0, 1, 0, "R10");
    step(1, 0, '0, 0, 3'd1, 0, 0, 0, "R10");
    // R11 settings changed mid-burst
    step(1, 1, 10'h155, 0, 3'd3, 1, 0, 0, "R11");
    for (int i = 0; i < 8; i++) step(1, 0, '0, 1, 3'(i % 8), ~i[0], 0, 1, "R11");
    idle(1, "R11");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic e, st, sp, wr, il, sw;
      logic [2:0] ln;
      e  = ($urandom % 100) < 85;
      st = ($urandom % 100) < 15;
      sp = ($urandom % 100) < 4;
      wr = $urandom % 2;
      il = $urandom % 2;
      sw = ($urandom % 100) < 30;
      ln = 3'($urandom % 8);
      step(e, st, 10'($urandom), wr, ln, il, sp, sw, "R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule